// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block is an up-counting interval timer that sits behind a simple word-addressed register port (address, write strobe, write data, combinational read data) and drives one interrupt line. Software programs a compare value, picks a clock divisor, and sets a run bit. From then on the counter advances once per divided tick. When it arrives at the compare value, a single-cycle interrupt pulse goes out. An optional auto-restart bit returns the count to zero on the tick that follows a hit. Without it the count runs on through the compare value and wraps at its full range.

The count can only be reset through a posted clear. A write to the clear register arms a short fixed delay. A pending bit in a status word stays high during that delay, and at the end the count is zeroed. The expected software sequence is: stop, clear, poll the pending bit until it drops, then restart. Stopping the timer keeps both the count and the compare value.

Top module: `match_tmr`

## Requirements
- R1: After reset every readable register (offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14) reads zero and `irq_o` is low.
- R2: The compare value is read/write at offset 0x00. Control at 0x08 holds run in bit 0 and auto-restart in bit 1. Bits of a written word that a register does not hold read back as zero.
- R3: The live count reads at offset 0x04 and ignores writes. It rises by one per tick only while run is set. When run is clear the count and the compare value hold.
- R4: The divide field is bits [1:0] at offset 0x10 and resets to 0. A value d makes one tick every d+1 clocks, so 3 gives one advance per four clocks.
- R5: With auto-restart clear, the count passes through the compare value and wraps from all-ones to zero.
- R6: With auto-restart set, the tick that follows a compare hit loads zero into the count, so the count never exceeds the compare value.
- R7: `irq_o` is a one-clock pulse in the cycle where the count first reads the compare value. It occurs only for a tick taken while run is set.
- R8: A write of any value to offset 0x0C sets the pending flag (bit 10 of the status word at 0x14) on the next edge. The flag stays set for three clocks. On the third edge after the write the count becomes zero and the flag drops. The clear register always reads zero.
- R9: The status word at 0x14 is read-only. Every bit except bit 10 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register being accessed |
| wr_en_i | input | 1 | Write strobe, taken on the rising clock edge |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Single-cycle compare-hit pulse |

## Verification
A register write takes effect on the edge that samples it, so a read-back is due one clock later. The count advances on the edge that ends each tick. The interrupt pulse appears in the same cycle in which the count first shows the compare value. The pending bit shows up one edge after a clear write and the count reads zero three edges after it. A behavioural reference in the bench advances on each rising edge from the same inputs. Outputs are compared with it at the following falling edge, and stimulus changes one nanosecond after that, so every comparison falls inside the cycle in which a result is due. Directed checks add fixed expectations for the clear timing sequence, the divide ratio, the wrap and the restart period.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   // Register offsets (byte addresses)
   localparam logic [7:0] OFS_CMP   = 8'h00;
   localparam logic [7:0] OFS_COUNT = 8'h04;
   localparam logic [7:0] OFS_CTRL  = 8'h08;
   localparam logic [7:0] OFS_CLR   = 8'h0C;
   localparam logic [7:0] OFS_DIV   = 8'h10;
   localparam logic [7:0] OFS_STAT  = 8'h14;

   // Control register fields
   typedef struct packed {
      logic auto_rst;   // bit 1
      logic run;        // bit 0
   } ctrl_t;

endpackage

// File: rtl/mmt_regs.sv
module mmt_regs
   import mmt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 32,
   parameter int DIV_W    = 2,
   parameter int PEND_BIT = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              pend_i,
   output logic [CNT_W-1:0]  cmp_o,
   output ctrl_t             ctrl_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              clr_req_o,
   output logic [DATA_W-1:0] rd_data_o
);

   logic              hit_cmp, hit_ctrl, hit_div, hit_clr;
   logic [DATA_W-1:0] cnt_ext, cmp_ext, ctrl_ext, div_ext, stat_w;

   assign hit_cmp  = wr_en_i && (addr_i == ADDR_W'(OFS_CMP));
   assign hit_ctrl = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
   assign hit_div  = wr_en_i && (addr_i == ADDR_W'(OFS_DIV));
   assign hit_clr  = wr_en_i && (addr_i == ADDR_W'(OFS_CLR));

   assign clr_req_o = hit_clr;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmp_o  <= '0;
         ctrl_o <= '0;
         div_o  <= '0;
      end else begin
         if (hit_cmp)  cmp_o  <= wr_data_i[CNT_W-1:0];
         if (hit_ctrl) ctrl_o <= ctrl_t'(wr_data_i[1:0]);
         if (hit_div)  div_o  <= wr_data_i[DIV_W-1:0];
      end
   end

   // Zero-extend counter-width values onto the data bus
   generate
      if (CNT_W == DATA_W) begin : g_full
         assign cnt_ext = cnt_i;
         assign cmp_ext = cmp_o;
      end else begin : g_pad
         assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
         assign cmp_ext = {{(DATA_W-CNT_W){1'b0}}, cmp_o};
      end
   endgenerate

   assign ctrl_ext = {{(DATA_W-2){1'b0}}, ctrl_o};
   assign div_ext  = {{(DATA_W-DIV_W){1'b0}}, div_o};

   always_comb begin
      stat_w           = '0;
      stat_w[PEND_BIT] = pend_i;
   end

   always_comb begin
      case (addr_i)
         ADDR_W'(OFS_CMP):   rd_data_o = cmp_ext;
         ADDR_W'(OFS_COUNT): rd_data_o = cnt_ext;
         ADDR_W'(OFS_CTRL):  rd_data_o = ctrl_ext;
         ADDR_W'(OFS_DIV):   rd_data_o = div_ext;
         ADDR_W'(OFS_STAT):  rd_data_o = stat_w;
         default:            rd_data_o = '0;
      endcase
   end

endmodule

// File: rtl/mmt_presc.sv
module mmt_presc #(
   parameter int DIV_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] phase_q;

   // ">=" keeps the divider sane when div_i shrinks mid-period
   assign tick_o = run_i && (phase_q >= div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      phase_q <= '0;
      else if (!run_i)  phase_q <= '0;
      else if (tick_o)  phase_q <= '0;
      else              phase_q <= phase_q + 1'b1;
   end

endmodule

// File: rtl/mmt_core.sv
module mmt_core #(
   parameter int CNT_W   = 32,
   parameter int CLR_DLY = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             auto_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             clr_req_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pend_o,
   output logic             irq_o
);

   localparam int DW = $clog2(CLR_DLY + 1);

   logic [DW-1:0]    dly_q;
   logic             clr_fire;
   logic             restart;
   logic [CNT_W-1:0] cnt_nxt;

   assign pend_o   = (dly_q != '0);
   assign clr_fire = (dly_q == DW'(1));
   assign restart  = auto_i && (cnt_o == cmp_i);
   assign cnt_nxt  = restart ? '0 : cnt_o + 1'b1;

   // Posted clear: reload on request, count down to the zeroing edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dly_q <= '0;
      else if (clr_req_i) dly_q <= DW'(CLR_DLY);
      else if (pend_o)    dly_q <= dly_q - 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o <= '0;
      else if (clr_fire) cnt_o <= '0;
      else if (tick_i)   cnt_o <= cnt_nxt;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= tick_i && !clr_fire && (cnt_nxt == cmp_i);
   end

endmodule

// File: rtl/match_tmr.sv
module match_tmr
   import mmt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int CNT_W    = 32,
   parameter int DIV_W    = 2,
   parameter int CLR_DLY  = 3,
   parameter int PEND_BIT = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);

   generate
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("match_tmr: CNT_W must be 2..DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("match_tmr: ADDR_W must reach offset 0x14");
      end
      if (CLR_DLY < 1) begin : g_bad_dly
         $error("match_tmr: CLR_DLY must be at least 1");
      end
      if (PEND_BIT >= DATA_W || DIV_W < 1 || DIV_W > DATA_W) begin : g_bad_fld
         $error("match_tmr: field position out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_q;
   ctrl_t            ctrl_q;
   logic [DIV_W-1:0] div_q;
   logic             clr_req;
   logic             pend_w;
   logic             tick_w;

   mmt_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .DIV_W(DIV_W), .PEND_BIT(PEND_BIT)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (addr_i),
      .wr_en_i  (wr_en_i),
      .wr_data_i(wr_data_i),
      .cnt_i    (cnt_q),
      .pend_i   (pend_w),
      .cmp_o    (cmp_q),
      .ctrl_o   (ctrl_q),
      .div_o    (div_q),
      .clr_req_o(clr_req),
      .rd_data_o(rd_data_o)
   );

   mmt_presc #(.DIV_W(DIV_W)) u_presc (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (ctrl_q.run),
      .div_i (div_q),
      .tick_o(tick_w)
   );

   mmt_core #(.CNT_W(CNT_W), .CLR_DLY(CLR_DLY)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w),
      .auto_i   (ctrl_q.auto_rst),
      .cmp_i    (cmp_q),
      .clr_req_i(clr_req),
      .cnt_o    (cnt_q),
      .pend_o   (pend_w),
      .irq_o    (irq_o)
   );

endmodule

// File: rtl/mmt_chk.sv
module mmt_chk #(
   parameter int CNT_W   = 32,
   parameter int CLR_DLY = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tick,
   input logic             run,
   input logic             auto_rst,
   input logic [CNT_W-1:0] cmp,
   input logic [CNT_W-1:0] cnt,
   input logic             pend,
   input logic             irq
);

   // R3: a stopped timer with no clear pending holds its count
   p_hold_stopped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !pend) |=> $stable(cnt));

   // R6: a tick on a compare hit with auto-restart gives zero
   p_restart_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_rst && tick && cnt == cmp) |=> (cnt == '0));

   // R7: interrupt is a single-cycle pulse
   p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq && (cmp != '0 || !auto_rst)) |=> !irq);

   // R7: interrupt only from a tick taken while running
   p_irq_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq |-> $past(run));

   // R8: when pending drops the count is zero
   p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend) |-> (cnt == '0));

   // R8: pending lasts more than one cycle
   p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((CLR_DLY > 1) && $rose(pend)) |=> pend);

endmodule

bind match_tmr mmt_chk #(.CNT_W(CNT_W), .CLR_DLY(CLR_DLY)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick    (tick_w),
   .run     (ctrl_q.run),
   .auto_rst(ctrl_q.auto_rst),
   .cmp     (cmp_q),
   .cnt     (cnt_q),
   .pend    (pend_w),
   .irq     (irq_o)
);

// File: tb/match_tmr_tb_top.sv
`timescale 1ns/1ps
module match_tmr_tb_top;

   localparam int TB_CW = 10;
   localparam logic [31:0] MSK = (32'd1 << TB_CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0, n_err = 0;
   int irq_seen = 0;
   logic [31:0] max_cnt = '0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   match_tmr #(.CNT_W(TB_CW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
      .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] m_cmp, m_cnt, m_pre, m_nv;
   logic [1:0]  m_div;
   logic        m_run, m_auto, m_irq, m_tick;
   int          m_clr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmp = 0; m_cnt = 0; m_pre = 0; m_div = 0;
         m_run = 0; m_auto = 0; m_irq = 0; m_clr = 0;
      end else begin
         m_tick = m_run && (m_pre >= 32'(m_div));
         m_nv   = (m_auto && m_cnt == m_cmp) ? 32'd0 : ((m_cnt + 1) & MSK);
         m_irq  = m_tick && (m_clr != 1) && (m_nv == m_cmp);
         if (m_clr == 1)  m_cnt = 0;
         else if (m_tick) m_cnt = m_nv;
         if (!m_run)      m_pre = 0;
         else if (m_tick) m_pre = 0;
         else             m_pre = m_pre + 1;
         if (wr_en && addr == 5'h0C) m_clr = 3;
         else if (m_clr > 0)         m_clr = m_clr - 1;
         if (wr_en && addr == 5'h00) m_cmp = wdata & MSK;
         if (wr_en && addr == 5'h08) begin m_run = wdata[0]; m_auto = wdata[1]; end
         if (wr_en && addr == 5'h10) m_div = wdata[1:0];
      end
   end

   function automatic logic [31:0] m_read(input logic [4:0] a);
      case (a)
         5'h00:   return m_cmp;
         5'h04:   return m_cnt;
         5'h08:   return {30'd0, m_auto, m_run};
         5'h10:   return {30'd0, m_div};
         5'h14:   return (m_clr != 0) ? 32'h400 : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [4:0] a);
      case (a)
         5'h00, 5'h08: return "R2";
         5'h04:        return "R3";
         5'h0C:        return "R8";
         5'h10:        return "R4";
         default:      return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag_of(addr), rdata, m_read(addr));
         check("R7", {31'd0, irq}, {31'd0, m_irq});
         if (irq) irq_seen++;
         if (addr == 5'h04 && rdata > max_cnt) max_cnt = rdata;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); #1; wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); #1; addr = a; wr_en = 1'b0;
      @(negedge clk); check(req, rdata, exp);
   endtask

   task automatic idle(input int n, input logic [4:0] a);
      @(negedge clk); #1; addr = a; wr_en = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_wait();
      wr(5'h0C, 32'h0);
      idle(4, 5'h14);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [31:0] snap;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values
      check("R1", {31'd0, irq}, 32'd0);
      for (int a = 0; a <= 20; a += 4) rd_chk(5'(a), 32'h0, "R1");

      // R2: register read-back and unused bits
      wr(5'h00, 32'hFFFF_FC05);
      rd_chk(5'h00, 32'h005, "R2");
      wr(5'h08, 32'hFFFF_FFF2);
      rd_chk(5'h08, 32'h2, "R2");
      wr(5'h08, 32'h0);
      wr(5'h10, 32'hFFFF_FFFE);
      rd_chk(5'h10, 32'h2, "R4");
      wr(5'h10, 32'h0);

      // R3: count ignores writes, advances when running, holds when stopped
      wr(5'h04, 32'd123);
      rd_chk(5'h04, 32'h0, "R3");
      wr(5'h00, 32'd1000);
      wr(5'h08, 32'h1);
      idle(20, 5'h04);
      wr(5'h08, 32'h0);
      @(negedge clk); #1; addr = 5'h04;
      @(negedge clk); snap = rdata;
      check("R3", {31'd0, (snap >= 32'd18 && snap <= 32'd24)}, 32'd1);
      idle(6, 5'h04);
      rd_chk(5'h04, snap, "R3");
      rd_chk(5'h00, 32'd1000, "R3");

      // R8: posted clear timing
      @(negedge clk); #1; addr = 5'h0C; wdata = 32'hDEAD_BEEF; wr_en = 1'b1;
      @(negedge clk); check("R8", rdata, 32'h0);
      #1; addr = 5'h14; wr_en = 1'b0;
      @(negedge clk); check("R8", rdata, 32'h400);
      @(negedge clk); check("R8", rdata, 32'h400);
      @(negedge clk); check("R8", rdata, 32'h0);
      rd_chk(5'h04, 32'h0, "R8");

      // R4: divide by four
      wr(5'h10, 32'h3);
      wr(5'h08, 32'h1);
      idle(40, 5'h04);
      wr(5'h08, 32'h0);
      @(negedge clk); #1; addr = 5'h04;
      @(negedge clk);
      check("R4", {31'd0, (rdata >= 32'd9 && rdata <= 32'd11)}, 32'd1);
      wr(5'h10, 32'h0);

      // R5/R7: wrap past the compare value, one pulse
      clear_wait();
      irq_seen = 0;
      wr(5'h08, 32'h1);
      idle(1030, 5'h04);
      wr(5'h08, 32'h0);
      check("R7", 32'(irq_seen), 32'd1);
      @(negedge clk); #1; addr = 5'h04;
      @(negedge clk);
      check("R5", {31'd0, (rdata < 32'd20)}, 32'd1);

      // R7: no pulse while stopped
      irq_seen = 0;
      idle(30, 5'h04);
      check("R7", 32'(irq_seen), 32'd0);

      // R6: auto-restart keeps count at or below compare value
      clear_wait();
      wr(5'h00, 32'd4);
      wr(5'h08, 32'h3);
      irq_seen = 0;
      max_cnt = 0;
      idle(50, 5'h04);
      wr(5'h08, 32'h0);
      check("R6", {31'd0, (max_cnt == 32'd4)}, 32'd1);
      check("R6", {31'd0, (irq_seen >= 9 && irq_seen <= 11)}, 32'd1);

      // R9: status ignores writes, clear register reads zero
      clear_wait();
      wr(5'h14, 32'hFFFF_FFFF);
      rd_chk(5'h14, 32'h0, "R9");
      rd_chk(5'h0C, 32'h0, "R8");

      idle(3, 5'h00);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule